// File: doc/BRIEF.md
# Reset Source Controller

This block sequences the resets of a clock generator's configuration register bank. Three events start a reset. The first is a hard reset: an active-low pin that is pulled low asynchronously. The second is a soft reset, requested by a decoded register write to the control register. The third is a reload request, written to a separate reload register. For each reset the block decides whether the configuration comes back from nonvolatile storage or from built-in defaults. A strap pin makes that choice. While any reset is in progress the block holds the clock outputs static. It emits a one-cycle ready pulse when they may toggle again. After a hard reset only, it also emits a phase-alignment sync pulse.

Nonvolatile storage appears only as a request/done handshake. `nv_load_req` rises and stays high until the storage returns a one-cycle `nv_load_done`. There is no back-pressure beyond that: the request simply waits. The defaults path is stood in for by a parameterized delay of `DEF_CYCLES` clocks, which starts with a one-cycle `def_load` strobe. Register writes arrive already decoded, synchronous to `clk`. `sclk_tick` marks each serial-clock edge as seen in the `clk` domain.

Top module: `rst_src_ctrl`

## Requirements
- R1: Driving `hard_rst_n` low immediately, with no clock edge needed, sets `outputs_hold` to 1 and clears the control register readback `ctrl_q` to 0 and `reload_pend` to 0.
- R2: After a hard reset the restore source is chosen from `strap_nv`. With 1, `nv_load_req` stays high until `nv_load_done` is sampled. With 0, `def_load` pulses for one cycle and the defaults load lasts `DEF_CYCLES` cycles. The two are never active together.
- R3: `sync_req` pulses for one cycle, together with `out_ready`, only at the end of a reset sequence that began with a hard reset. It never pulses after a soft reset or a reload.
- R4: A soft reset starts only when a control write (`wr_sel`=0) has bit 2 and bit 5 both set. A control write with only one of them set starts no reset; it stores its other bits and reads those two bits as 0.
- R5: A soft reset restores from nonvolatile storage when `strap_nv` is 1 and from defaults when it is 0.
- R6: During a soft reset, bits 2 and 5 read back as 1 and outputs stay held. They clear at the first `sclk_tick` sampled after the request cycle, and only then does loading start. All other control bits keep the value written.
- R7: `outputs_hold` is 1 whenever the block is not in normal running. `out_ready` is a single-cycle pulse in the first running cycle after a reset sequence.
- R8: A reload write (`wr_sel`=1, bit 1 set) with `strap_nv`=0 starts a load from nonvolatile storage. `reload_pend` reads 1 until the load completes. With `strap_nv`=1 the write has no effect.
- R9: Register writes arriving while a reset sequence is in progress are ignored.
- R10: Release of `hard_rst_n` is synchronized by a two-stage chain, so no load starts before the third rising clock edge after release.

Bit positions: the soft-reset request is bits 2 and 5 of the control register, and the reload request is bit 1 of the reload register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; register writes are synchronous to it |
| hard_rst_n | input | 1 | Asynchronous active-low hard reset |
| strap_nv | input | 1 | Restore source strap: 1 nonvolatile, 0 defaults |
| sclk_tick | input | 1 | One-cycle marker of a serial-clock edge |
| wr_en | input | 1 | Decoded register write strobe |
| wr_sel | input | 1 | 0 control register, 1 reload register |
| wr_data | input | 8 | Write data |
| nv_load_req | output | 1 | Load from nonvolatile storage, held until done |
| nv_load_done | input | 1 | One-cycle completion from nonvolatile storage |
| def_load | output | 1 | One-cycle strobe starting the defaults load |
| outputs_hold | output | 1 | Clock outputs must stay static |
| out_ready | output | 1 | One-cycle pulse: outputs may toggle |
| sync_req | output | 1 | One-cycle phase-alignment request after a hard reset |
| ctrl_q | output | 8 | Control register readback |
| reload_pend | output | 1 | Reload register bit readback |

## Verification
The assertions check several properties on every cycle. Outputs are held whenever a load is running, a soft-reset request bit is visible or a reload is pending. The two load sources never overlap. Sync never appears without ready, and ready lasts one cycle. The request bits cannot clear before a serial-clock tick. Only the bench scenarios can show the rest. These are the asynchronous effect of the reset pin between clock edges, the strap-driven choice of source, the exact `DEF_CYCLES` length of the defaults path, and the fact that one-bit soft writes, strap-high reloads and writes during a reset leave no trace.

// File: rtl/rst_src_pkg.sv
package rst_src_pkg;
  typedef enum logic [2:0] {
    PH_BOOT,
    PH_RUN,
    PH_WAIT_SCLK,
    PH_LOAD_NV,
    PH_LOAD_DEF
  } phase_e;
endpackage

// File: rtl/rst_src_sync.sv
// Reset synchronizer: asserts asynchronously, releases after STAGES edges.
module rst_src_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/rst_src_regs.sv
// Control and reload registers with self-clearing request bits.
module rst_src_regs #(
  parameter int W          = 8,
  parameter int SOFT_A     = 2,
  parameter int SOFT_B     = 5,
  parameter int RELOAD_BIT = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         strap_nv,
  input  logic         accept,
  input  logic         clr_soft,
  input  logic         clr_reload,
  output logic [W-1:0] ctrl_q,
  output logic         reload_q,
  output logic         soft_go,
  output logic         reload_go
);
  localparam logic [W-1:0] SOFT_MASK = (W'(1) << SOFT_A) | (W'(1) << SOFT_B);

  logic ctrl_wr;

  assign ctrl_wr   = accept & wr_en & ~wr_sel;
  assign soft_go   = ctrl_wr & wr_data[SOFT_A] & wr_data[SOFT_B];
  assign reload_go = accept & wr_en & wr_sel & wr_data[RELOAD_BIT] & ~strap_nv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= 1'b0;
    end else begin
      if (soft_go)       ctrl_q <= wr_data;
      else if (ctrl_wr)  ctrl_q <= wr_data & ~SOFT_MASK;
      else if (clr_soft) ctrl_q <= ctrl_q & ~SOFT_MASK;

      if (reload_go)       reload_q <= 1'b1;
      else if (clr_reload) reload_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rst_src_fsm.sv
// Reset sequencer: source choice, serial-clock wait, load tracking.
module rst_src_fsm
  import rst_src_pkg::*;
#(
  parameter int DEF_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_nv,
  input  logic soft_go,
  input  logic reload_go,
  input  logic sclk_tick,
  input  logic nv_load_done,
  output logic run,
  output logic clr_soft,
  output logic clr_reload,
  output logic nv_load_req,
  output logic def_load,
  output logic outputs_hold,
  output logic ready,
  output logic sync_req
);
  localparam int CW = $clog2(DEF_CYCLES) + 1;
  localparam logic [CW-1:0] LAST = CW'(DEF_CYCLES - 1);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q;
  logic          hard_q, ready_q, sync_q, finish;
  phase_e        src_ph;

  assign src_ph = strap_nv ? PH_LOAD_NV : PH_LOAD_DEF;
  assign finish = ((ph_q == PH_LOAD_NV) && nv_load_done) ||
                  ((ph_q == PH_LOAD_DEF) && (cnt_q == LAST));

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_BOOT:      ph_d = src_ph;
      PH_RUN: begin
        if (soft_go)        ph_d = PH_WAIT_SCLK;
        else if (reload_go) ph_d = PH_LOAD_NV;
      end
      PH_WAIT_SCLK: if (sclk_tick) ph_d = src_ph;
      PH_LOAD_NV,
      PH_LOAD_DEF:  if (finish) ph_d = PH_RUN;
      default:      ph_d = PH_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_BOOT;
      cnt_q   <= '0;
      hard_q  <= 1'b1;
      ready_q <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= (ph_q == PH_LOAD_DEF) ? cnt_q + CW'(1) : '0;
      ready_q <= finish;
      sync_q  <= finish & hard_q;
      if (finish) hard_q <= 1'b0;
    end
  end

  assign run          = (ph_q == PH_RUN);
  assign clr_soft     = (ph_q == PH_WAIT_SCLK) && sclk_tick;
  assign clr_reload   = (ph_q == PH_LOAD_NV) && nv_load_done;
  assign nv_load_req  = (ph_q == PH_LOAD_NV);
  assign def_load     = (ph_q == PH_LOAD_DEF) && (cnt_q == '0);
  assign outputs_hold = (ph_q != PH_RUN);
  assign ready        = ready_q;
  assign sync_req     = sync_q;
endmodule

// File: rtl/rst_src_ctrl.sv
module rst_src_ctrl #(
  parameter int DEF_CYCLES = 16,
  parameter int SYNC_STAGES = 2,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         hard_rst_n,
  input  logic         strap_nv,
  input  logic         sclk_tick,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  output logic         nv_load_req,
  input  logic         nv_load_done,
  output logic         def_load,
  output logic         outputs_hold,
  output logic         out_ready,
  output logic         sync_req,
  output logic [W-1:0] ctrl_q,
  output logic         reload_pend
);
  logic rst_n_s, run, clr_soft, clr_reload, soft_go, reload_go;

  rst_src_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(hard_rst_n), .rst_n_o(rst_n_s)
  );

  rst_src_regs #(.W(W), .SOFT_A(2), .SOFT_B(5), .RELOAD_BIT(1)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .strap_nv(strap_nv), .accept(run),
    .clr_soft(clr_soft), .clr_reload(clr_reload), .ctrl_q(ctrl_q),
    .reload_q(reload_pend), .soft_go(soft_go), .reload_go(reload_go)
  );

  rst_src_fsm #(.DEF_CYCLES(DEF_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .strap_nv(strap_nv), .soft_go(soft_go),
    .reload_go(reload_go), .sclk_tick(sclk_tick),
    .nv_load_done(nv_load_done), .run(run), .clr_soft(clr_soft),
    .clr_reload(clr_reload), .nv_load_req(nv_load_req),
    .def_load(def_load), .outputs_hold(outputs_hold), .ready(out_ready),
    .sync_req(sync_req)
  );
endmodule

// File: rtl/rst_src_ctrl_chk.sv
module rst_src_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         hard_rst_n,
  input logic         sclk_tick,
  input logic         nv_load_req,
  input logic         def_load,
  input logic         outputs_hold,
  input logic         out_ready,
  input logic         sync_req,
  input logic [W-1:0] ctrl_q,
  input logic         reload_pend
);
  logic soft_set;
  assign soft_set = ctrl_q[2] && ctrl_q[5];

  AST_LOAD_HOLDS: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (nv_load_req || def_load) |-> outputs_hold); // R7
  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!hard_rst_n)
    !(nv_load_req && def_load)); // R2
  AST_READY_RELEASES: assert property (@(posedge clk) disable iff (!hard_rst_n)
    out_ready |-> (!outputs_hold && $past(outputs_hold))); // R7
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!hard_rst_n)
    out_ready |=> !out_ready); // R7
  AST_SYNC_WITH_READY: assert property (@(posedge clk) disable iff (!hard_rst_n)
    sync_req |-> out_ready); // R3
  AST_SOFT_BITS_HOLD: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (ctrl_q[2] || ctrl_q[5]) |-> outputs_hold); // R6
  AST_NO_TICK_NO_CLEAR: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (soft_set && !sclk_tick) |=> soft_set); // R6
  AST_RELOAD_HOLDS: assert property (@(posedge clk) disable iff (!hard_rst_n)
    reload_pend |-> outputs_hold); // R8
endmodule

bind rst_src_ctrl rst_src_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .hard_rst_n(hard_rst_n), .sclk_tick(sclk_tick),
  .nv_load_req(nv_load_req), .def_load(def_load),
  .outputs_hold(outputs_hold), .out_ready(out_ready), .sync_req(sync_req),
  .ctrl_q(ctrl_q), .reload_pend(reload_pend)
);

// File: tb/rst_src_ctrl_bench.sv
`timescale 1ns/1ps
module rst_src_ctrl_bench;
  localparam int DEF_N = 16;

  logic clk = 1'b0;
  logic hard_rst_n = 1'b0, strap_nv = 1'b1, sclk_tick = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, nv_load_done = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic nv_load_req, def_load, outputs_hold, out_ready, sync_req, reload_pend;
  logic [7:0] ctrl_q;

  int vectors = 0, fails = 0, cyc = 0, lat = 0;

  always #5 clk = ~clk;

  rst_src_ctrl #(.DEF_CYCLES(DEF_N)) u_rst_src_ctrl (
    .clk(clk), .hard_rst_n(hard_rst_n), .strap_nv(strap_nv),
    .sclk_tick(sclk_tick), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .nv_load_req(nv_load_req), .nv_load_done(nv_load_done),
    .def_load(def_load), .outputs_hold(outputs_hold), .out_ready(out_ready),
    .sync_req(sync_req), .ctrl_q(ctrl_q), .reload_pend(reload_pend)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: mode 0 run, 1 wait serial tick, 2 nv load,
  // 3 defaults load, 4 boot; rel counts edges since pin release.
  int  m_mode = 4, m_rel = 0, m_cnt = 0;
  bit  m_hard = 1, m_ready = 0, m_sync = 0, m_rl = 0;
  logic [7:0] m_ctrl = 8'h00;

  always @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n) begin
      m_mode = 4; m_rel = 0; m_cnt = 0; m_hard = 1;
      m_ready = 0; m_sync = 0; m_rl = 0; m_ctrl = 8'h00;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      m_ready = 0; m_sync = 0;
      case (m_mode)
        4: begin m_mode = strap_nv ? 2 : 3; m_cnt = 0; end
        0: if (wr_en) begin
             if (!wr_sel) begin
               if (wr_data[2] && wr_data[5]) begin m_ctrl = wr_data; m_mode = 1; end
               else m_ctrl = wr_data & 8'hDB;
             end else if (wr_data[1] && !strap_nv) begin
               m_rl = 1; m_mode = 2;
             end
           end
        1: if (sclk_tick) begin
             m_ctrl = m_ctrl & 8'hDB; m_mode = strap_nv ? 2 : 3; m_cnt = 0;
           end
        2: if (nv_load_done) begin
             m_rl = 0; m_mode = 0; m_ready = 1; m_sync = m_hard; m_hard = 0;
           end
        default: if (m_cnt == DEF_N - 1) begin
             m_mode = 0; m_ready = 1; m_sync = m_hard; m_hard = 0;
           end else m_cnt++;
      endcase
    end
  end

  // Compare on every clock, away from the rising edge.
  always @(negedge clk) begin
    chk(outputs_hold == (m_mode != 0), "R7 hold", outputs_hold, m_mode != 0);
    chk(out_ready == m_ready, "R7 ready", out_ready, m_ready);
    chk(nv_load_req == (m_mode == 2), "R2 nv_req", nv_load_req, m_mode == 2);
    chk(def_load == (m_mode == 3 && m_cnt == 0), "R2 def_load", def_load,
        m_mode == 3 && m_cnt == 0);
    chk(sync_req == m_sync, "R3 sync", sync_req, m_sync);
    chk(ctrl_q == m_ctrl, "R6 ctrl", ctrl_q, m_ctrl);
    chk(reload_pend == m_rl, "R8 reload", reload_pend, m_rl);
  end

  // Nonvolatile storage responder: done after three cycles of request.
  always @(negedge clk) begin
    if (!hard_rst_n) begin lat = 0; nv_load_done <= 1'b0; end
    else if (nv_load_req && !nv_load_done) begin
      lat++;
      if (lat == 3) begin nv_load_done <= 1'b1; lat = 0; end
    end else nv_load_done <= 1'b0;
  end

  // Watchdog
  always @(negedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic tick();
    @(negedge clk); sclk_tick = 1'b1;
    @(negedge clk); sclk_tick = 1'b0;
  endtask

  task automatic wait_ready(input string tag, output bit saw_sync);
    bit seen = 0;
    saw_sync = 0;
    for (int i = 0; i < 300 && !seen; i++) begin
      @(negedge clk);
      if (out_ready) begin seen = 1; saw_sync = sync_req; end
    end
    chk(seen, tag, seen, 1);
  endtask

  task automatic pulse_reset(input logic s);
    @(negedge clk); strap_nv = s; hard_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    hard_rst_n = 1'b1;
  endtask

  initial begin
    bit sy;
    int n;
    // R1: state while the pin is low
    repeat (3) @(negedge clk);
    chk(outputs_hold && ctrl_q == 0 && !reload_pend, "R1 reset state",
        {outputs_hold, ctrl_q}, 9'h100);
    hard_rst_n = 1'b1;
    @(negedge clk);
    chk(!nv_load_req && !def_load, "R10 no early load", nv_load_req, 0);
    @(negedge clk);
    chk(!nv_load_req, "R10 still synchronizing", nv_load_req, 0);
    @(negedge clk);
    chk(nv_load_req, "R2 nv path from strap 1", nv_load_req, 1);
    wait_ready("R2 nv load completes", sy);
    chk(sy, "R3 sync after hard reset", sy, 1);

    // R4: single-bit writes do not start a reset
    wr(1'b0, 8'h41);
    chk(ctrl_q == 8'h41 && !outputs_hold, "R4 plain write", ctrl_q, 8'h41);
    wr(1'b0, 8'h45);
    chk(ctrl_q == 8'h41 && !outputs_hold, "R4 bit2 only", ctrl_q, 8'h41);
    wr(1'b0, 8'hA1);
    chk(ctrl_q == 8'h81 && !outputs_hold, "R4 bit5 only", ctrl_q, 8'h81);

    // R6/R5: soft reset waits for a serial tick, then nv path
    wr(1'b0, 8'h65);
    chk(ctrl_q == 8'h65 && outputs_hold, "R6 request visible", ctrl_q, 8'h65);
    repeat (5) @(negedge clk);
    chk(ctrl_q == 8'h65 && !nv_load_req, "R6 held without tick", ctrl_q, 8'h65);
    wr(1'b0, 8'h10);
    chk(ctrl_q == 8'h65, "R9 write during reset ignored", ctrl_q, 8'h65);
    tick();
    chk(ctrl_q == 8'h41 && nv_load_req, "R5 nv after tick", ctrl_q, 8'h41);
    wait_ready("R5 soft nv completes", sy);
    chk(!sy, "R3 no sync after soft", sy, 0);

    // R5: soft reset with strap low takes defaults path of DEF_N cycles
    strap_nv = 1'b0;
    wr(1'b0, 8'h24);
    tick();
    chk(def_load, "R5 defaults after tick", def_load, 1);
    n = 0;
    while (!out_ready && n < 100) begin @(negedge clk); n++; end
    chk(n == DEF_N, "R2 defaults length", n, DEF_N);
    chk(!sync_req, "R3 no sync after soft defaults", sync_req, 0);

    // R8: reload with strap low
    wr(1'b1, 8'h02);
    chk(reload_pend && nv_load_req, "R8 reload starts", reload_pend, 1);
    wait_ready("R8 reload completes", sy);
    chk(!reload_pend && !sy, "R8 reload cleared", reload_pend, 0);

    // R8: reload ignored with strap high
    strap_nv = 1'b1;
    wr(1'b1, 8'h02);
    chk(!reload_pend && !outputs_hold && !nv_load_req, "R8 ignored strap high",
        {reload_pend, outputs_hold}, 0);
    repeat (3) @(negedge clk);
    chk(!outputs_hold, "R8 stays running", outputs_hold, 0);

    // R1: asynchronous effect between clock edges
    @(negedge clk); #2 hard_rst_n = 1'b0; #1;
    chk(outputs_hold && ctrl_q == 0, "R1 async assert", {outputs_hold, ctrl_q}, 9'h100);
    @(negedge clk); hard_rst_n = 1'b1;

    // R2/R3: hard reset with strap low
    pulse_reset(1'b0);
    wait_ready("R2 hard defaults completes", sy);
    chk(sy, "R3 sync after hard defaults", sy, 1);
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule